// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for a clause-22 MDIO bus. Software sees two 32-bit registers. The control register holds an enable bit, an idle flag and the MDC clock divider. The access register holds the command, the PHY and register addresses, the 16-bit data word, a busy/start bit and an acknowledge bit. When software writes the access register with the start bit set, the block runs one complete read or write frame on MDC/MDIO.

While the frame runs, the start bit reads back as 1. Software polls that bit until it clears. After a read, the captured data and the acknowledge result sit in the same access register. The MDIO pin is split into three signals (output value, output enable and input) so that an I/O cell outside the block can form the bidirectional pad.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads 0x8000_0000 and the access register reads 0. MDC and the MDIO output enable are both low.
- R2: Access register layout: bit 31 start/busy, bit 30 write (1) or read (0), bit 29 acknowledge, bits 28:26 read as 0, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data.
- R3: Control register layout: bit 31 reads 1 when no frame is running and 0 while one runs, bit 30 is enable, and bits DIV_W-1:0 are the divider. Writing the access register never changes the control register.
- R4: If the block is idle and enable is 1, writing the access register with bit 31 set starts a frame. Bit 31 then reads 1 for exactly 128*(div+1) clock cycles and clears itself.
- R5: While a frame runs, MDC has a period of 2*(div+1) clock cycles, beginning with a low half. MDC is held low when no frame runs.
- R6: A frame is sent MSB first, with one bit per MDC period, and MDIO changes only on a falling MDC edge. The field order is: 32 ones, then 01, then an opcode (10 for a read, 01 for a write), then the 5-bit PHY address, then the 5-bit register address.
- R7: On a write, the block drives MDIO for all 64 bits, with turnaround 10 followed by the 16 data bits. Afterwards the acknowledge bit is 0 and the data field keeps the written word.
- R8: On a read, the output enable drops at the first turnaround bit and stays low for the rest of the frame. The 16 data bits are sampled on rising MDC edges, and the data field holds them when bit 31 clears.
- R9: After a read, the acknowledge bit is 1 exactly when MDIO was low at the rising MDC edge of the second turnaround bit. It is 0 after any write.
- R10: While bit 31 is 1, writes to the access register are ignored.
- R11: When enable is 0, a write with bit 31 set starts no frame. Bit 31 stays 0, the other fields are stored, and the acknowledge bit is cleared.
- R12: The divider value is captured when a frame starts. Changing the control register during a frame does not change that frame's MDC timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register select: 0 control, 1 access |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register read value |
| access_rdata | output | 32 | Access register read value |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest behaviour to reach from the ports is a register write that lands in the middle of a running frame. This covers both an access write that must be ignored and a divider change that must not disturb the frame in flight. The stimulus issues both writes a fixed number of cycles into a read frame. It then checks the total busy time against the divider captured at the start, and confirms that the returned data still matches what the PHY model drove. The PHY model itself changes MDIO only on falling MDC edges. It can either pull the turnaround low or leave the line high, so that both acknowledge outcomes are exercised.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int MDIO_DATA_W = 16;
    localparam int MDIO_ADDR_W = 5;

    // Software view of the access register (bit 31 down to bit 0)
    typedef struct packed {
        logic                   go;
        logic                   wr;
        logic                   ack;
        logic [2:0]             rsvd;
        logic [MDIO_ADDR_W-1:0] regad;
        logic [MDIO_ADDR_W-1:0] phyad;
        logic [MDIO_DATA_W-1:0] data;
    } access_reg_t;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      wrap;

    assign wrap = (st_q.cnt == div_i);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o  = st_q.mdc;
    assign rise_o = run_i && wrap && !st_q.mdc;
    assign fall_o = run_i && wrap &&  st_q.mdc;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   wr_i,
    input  logic [MDIO_ADDR_W-1:0] phyad_i,
    input  logic [MDIO_ADDR_W-1:0] regad_i,
    input  logic [MDIO_DATA_W-1:0] wdata_i,
    input  logic                   rise_i,
    input  logic                   fall_i,
    input  logic                   mdio_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   mdio_o,
    output logic                   mdio_oe,
    output logic [MDIO_DATA_W-1:0] rdata_o,
    output logic                   ack_o
);

    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_IDX    = PRE_LEN + 14;
    localparam int DATA_IDX  = PRE_LEN + 16;
    localparam int LAST_IDX  = FRAME_LEN - 1;

    typedef struct packed {
        logic                   busy;
        logic                   wr;
        logic                   ack;
        logic [IDX_W-1:0]       idx;
        logic [FRAME_LEN-1:0]   sh;
        logic [MDIO_DATA_W-1:0] rx;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic       last_bit;

    assign last_bit = (st_q.idx == IDX_W'(LAST_IDX));

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.wr   = wr_i;
            st_d.ack  = 1'b0;
            st_d.idx  = '0;
            st_d.rx   = '0;
            st_d.sh   = {{PRE_LEN{1'b1}}, SOF_CODE,
                         (wr_i ? OP_WRITE : OP_READ),
                         phyad_i, regad_i,
                         (wr_i ? TA_WRITE : 2'b11),
                         (wr_i ? wdata_i : {MDIO_DATA_W{1'b1}})};
        end else if (st_q.busy) begin
            if (rise_i && !st_q.wr) begin
                if (st_q.idx == IDX_W'(TA_IDX + 1))
                    st_d.ack = !mdio_i;
                if (st_q.idx >= IDX_W'(DATA_IDX))
                    st_d.rx = {st_q.rx[MDIO_DATA_W-2:0], mdio_i};
            end
            if (fall_i) begin
                if (last_bit) begin
                    st_d.busy = 1'b0;
                    done_o    = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign mdio_o  = st_q.busy ? st_q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = st_q.busy && (st_q.wr || (st_q.idx < IDX_W'(TA_IDX)));
    assign rdata_o = st_q.rx;
    assign ack_o   = st_q.ack;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] access_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    localparam int CTRL_PAD_W = 30 - DIV_W;

    typedef struct packed {
        logic             enable;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] div_run;
        access_reg_t      acc;
    } top_state_t;

    top_state_t             st_d, st_q;
    access_reg_t            wr_acc;
    logic                   start;
    logic                   eng_busy;
    logic                   eng_done;
    logic                   eng_ack;
    logic [MDIO_DATA_W-1:0] eng_rdata;
    logic                   tick_rise;
    logic                   tick_fall;

    assign wr_acc = access_reg_t'(reg_wdata);

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (reg_wr && !reg_sel) begin
            st_d.enable = reg_wdata[30];
            st_d.div    = reg_wdata[DIV_W-1:0];
        end
        if (reg_wr && reg_sel && !st_q.acc.go) begin
            st_d.acc.wr    = wr_acc.wr;
            st_d.acc.regad = wr_acc.regad;
            st_d.acc.phyad = wr_acc.phyad;
            st_d.acc.data  = wr_acc.data;
            st_d.acc.ack   = 1'b0;
            if (wr_acc.go && st_q.enable) begin
                st_d.acc.go  = 1'b1;
                st_d.div_run = st_q.div;
                start        = 1'b1;
            end
        end
        if (eng_done) begin
            st_d.acc.go = 1'b0;
            if (!st_q.acc.wr) begin
                st_d.acc.data = eng_rdata;
                st_d.acc.ack  = eng_ack;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_clk_div #(
        .DIV_W (DIV_W)
    ) u_clk_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_busy),
        .div_i  (st_q.div_run),
        .mdc_o  (mdc),
        .rise_o (tick_rise),
        .fall_o (tick_fall)
    );

    mdio_frame_engine #(
        .PRE_LEN (PRE_LEN)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .wr_i    (wr_acc.wr),
        .phyad_i (wr_acc.phyad),
        .regad_i (wr_acc.regad),
        .wdata_i (wr_acc.data),
        .rise_i  (tick_rise),
        .fall_i  (tick_fall),
        .mdio_i  (mdio_i),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata_o (eng_rdata),
        .ack_o   (eng_ack)
    );

    assign ctrl_rdata   = {~st_q.acc.go, st_q.enable, {CTRL_PAD_W{1'b0}}, st_q.div};
    assign access_rdata = {st_q.acc.go, st_q.acc.wr, st_q.acc.ack, 3'b000,
                           st_q.acc.regad, st_q.acc.phyad, st_q.acc.data};

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] access_rdata,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        eng_done
);

    // R5
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !access_rdata[31] |-> !mdc);

    // R8
    oe_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !access_rdata[31] |-> !mdio_oe);

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && access_rdata[31] && !eng_done) |=> $stable(access_rdata[30:0]));

    // R4
    go_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_rdata[31]) |-> $past(reg_wr && reg_sel));

    // R9
    ack_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_rdata[29]) |-> !access_rdata[30]);

    // R3
    ctrl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> $stable(ctrl_rdata[30:0]));

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .ctrl_rdata   (ctrl_rdata),
    .access_rdata (access_rdata),
    .mdc          (mdc),
    .mdio_oe      (mdio_oe),
    .eng_done     (eng_done)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;

    localparam int DIV_W = 8;
    localparam int P     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [31:0] access_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // PHY behaviour chosen per test
    bit          ph_ta_low = 1'b0;
    logic [15:0] ph_data = 16'hFFFF;

    // reference model state
    bit          m_busy, m_enable, m_wr, m_ack;
    int          m_n, m_dr;
    logic [DIV_W-1:0] m_div;
    logic [4:0]  m_reg, m_phy;
    logic [15:0] m_data;
    logic [63:0] m_frame;

    always #10 clk = ~clk;

    mdio_mgmt_master #(.DIV_W(DIV_W), .PRE_LEN(P)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .access_rdata(access_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_enable <= 0; m_wr <= 0; m_ack <= 0; m_n <= 0; m_dr <= 0;
            m_div <= '0; m_reg <= '0; m_phy <= '0; m_data <= '0; m_frame <= '0;
        end else begin
            if (reg_wr && !reg_sel) begin
                m_enable <= reg_wdata[30];
                m_div    <= reg_wdata[DIV_W-1:0];
            end
            if (m_busy) begin
                m_n <= m_n + 1;
                if (m_n + 1 == 128 * (m_dr + 1)) begin
                    m_busy <= 0;
                    if (!m_wr) begin
                        m_data <= ph_data;
                        m_ack  <= ph_ta_low;
                    end
                end
            end else if (reg_wr && reg_sel) begin
                m_wr   <= reg_wdata[30];
                m_reg  <= reg_wdata[25:21];
                m_phy  <= reg_wdata[20:16];
                m_data <= reg_wdata[15:0];
                m_ack  <= 0;
                if (reg_wdata[31] && m_enable) begin
                    m_busy  <= 1;
                    m_n     <= 0;
                    m_dr    <= int'(m_div);
                    m_frame <= {32'hFFFF_FFFF, 2'b01,
                                reg_wdata[30] ? 2'b01 : 2'b10,
                                reg_wdata[20:16], reg_wdata[25:21],
                                reg_wdata[30] ? 2'b10 : 2'b11,
                                reg_wdata[30] ? reg_wdata[15:0] : 16'hFFFF};
                end
            end
        end
    end

    // per-cycle comparison and PHY drive, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int  bitn;
            bit  e_mdc, e_oe;
            bitn  = m_busy ? m_n / (2 * (m_dr + 1)) : 0;
            e_mdc = m_busy ? (((m_n / (m_dr + 1)) % 2) == 1) : 1'b0;
            e_oe  = m_busy && (m_wr || bitn < P + 14);
            chk("R5 mdc", {31'b0, mdc}, {31'b0, e_mdc});
            chk("R8 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) chk("R6 mdio bit", {31'b0, mdio_o}, {31'b0, m_frame[63 - bitn]});
            chk("R3 ctrl", ctrl_rdata, {!m_busy, m_enable, {(30-DIV_W){1'b0}}, m_div});
            chk("R2 access", access_rdata, {m_busy, m_wr, m_ack, 3'b000, m_reg, m_phy, m_data});
            if (m_busy && !m_wr && bitn == P + 15)      mdio_i <= !ph_ta_low;
            else if (m_busy && !m_wr && bitn >= P + 16) mdio_i <= ph_data[15 - (bitn - P - 16)];
            else                                        mdio_i <= 1'b1;
        end
    end

    task automatic wreg(input bit sel, input logic [31:0] val);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (access_rdata[31]) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_rdata, 32'h8000_0000);
        chk("R1 access", access_rdata, 32'h0);
        chk("R1 pins", {30'b0, mdc, mdio_oe}, 32'h0);

        // R7 write frame, div 1
        wreg(0, 32'h4000_0001);
        chk("R3 ctrl fields", ctrl_rdata, 32'hC000_0001);
        wreg(1, 32'hC151_A5C3);
        chk("R3 idle flag low", {31'b0, ctrl_rdata[31]}, 32'h0);
        wait_idle(n);
        chk("R4 busy length div1", n, 256);
        chk("R7 write result", access_rdata, 32'h4151_A5C3);

        // R8 R9 read with PHY answering, div 0
        ph_ta_low = 1'b1; ph_data = 16'h3C5A;
        wreg(0, 32'h4000_0000);
        wreg(1, 32'h83E1_0000);
        wait_idle(n);
        chk("R4 busy length div0", n, 128);
        chk("R9 read ack", access_rdata, 32'h23E1_3C5A);

        // R9 read with no PHY present
        ph_ta_low = 1'b0; ph_data = 16'hFFFF;
        wreg(1, 32'h8043_0000);
        wait_idle(n);
        chk("R9 no ack", access_rdata, 32'h0043_FFFF);

        // R10 R12 writes during a read frame, div 2
        ph_ta_low = 1'b1; ph_data = 16'h8001;
        wreg(0, 32'h4000_0002);
        wreg(1, 32'h80BE_0000);
        repeat (20) @(negedge clk);
        wreg(1, 32'hFFFF_FFFF);
        chk("R10 ignored", access_rdata, 32'h80BE_0000);
        wreg(0, 32'h4000_0000);
        chk("R12 ctrl updated", ctrl_rdata, 32'h4000_0000);
        wait_idle(n);
        chk("R12 frame length", n + 22, 384);
        chk("R8 read data", access_rdata, 32'h20BE_8001);

        // R11 start while disabled
        wreg(0, 32'h0000_0003);
        wreg(1, 32'hC0A9_1234);
        repeat (10) @(negedge clk);
        chk("R11 no frame", access_rdata, 32'h40A9_1234);
        chk("R11 mdc idle", {31'b0, mdc}, 32'h0);

        // R5 write frame with div 3
        wreg(0, 32'h4000_0003);
        wreg(1, 32'hC0A9_1234);
        wait_idle(n);
        chk("R5 busy length div3", n, 512);
        chk("R7 ack clear", access_rdata, 32'h40A9_1234);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule